// File: doc/BRIEF.md
# SD Command/Response Line Engine

This block drives the command line of a native SD bus as the bus master. A host request carries a 6-bit command index and a 32-bit argument. The engine turns these into a 48-bit frame with its CRC7 and clocks the frame out. It then stops the SD clock, releases the line and restarts the clock to hunt for the card's start bit. Once the start bit is found, it collects a 48-bit short response, checks it and clocks a fixed burst of guard pulses. Only then does it signal completion.

The SD clock is a divided system clock. A slow ratio is used during card initialisation, and a fast ratio of four system clocks per SD clock is used afterwards. The ratio is chosen per command. The incoming line passes through a short delay line, and a programmable tap chooses how many system clocks late the value is sampled. Every response CRC is checked. A CRC mismatch is taken as a sign that the sampling point has drifted, so the engine steps the tap by one, wrapping from the top back to zero, and latches a sticky flag. No retuning happens unless a mismatch occurs. If no start bit appears within a host-set number of SD clocks, the wait is abandoned as a timeout.

Top module: `sd_cmd_engine`

## Requirements
- R1: The frame leaves on `sd_cmd_out` most significant bit first, with `sd_cmd_oe` high. The 48 bits are: 0, 1, index[5:0], argument[31:0], then CRC7 (generator x^7+x^3+1, register cleared, computed over the preceding 40 bits), then 1. The line changes only after falling SD clock edges, so each bit is stable at its rising edge, and exactly 48 rising edges occur while the engine drives.
- R2: The SD clock period is FAST_DIV system clocks when `fast_sel` was 1 at `start`, and SLOW_DIV when it was 0. The clock is low for the first half of each period and high for the second half.
- R3: After the 48th command bit, the SD clock falls and `sd_cmd_oe` drops on the same edge. The clock then stays low for TURN_GAP + (period/2) system clocks before its next rising edge.
- R4: The response starts at the first rising SD clock edge at which the sampled line is 0. The card may wait any number of SD clocks, below the timeout limit, before sending it.
- R5: After `done`, `rsp_index` holds response bits 45..40 and `rsp_arg` holds bits 39..8, where bit 47 is the start bit.
- R6: `crc_err` is 1 after `done` exactly when the CRC7 of response bits 47..8 differs from bits 7..1.
- R7: `end_err` is 1 after `done` exactly when response bit 0 is 0.
- R8: A CRC error advances `dly_now` by one, modulo 2^DLY_W, pulses `recal_req` and sets `dly_adjusted`, which stays set until reset. Without a CRC error, `dly_now` does not change.
- R9: If `resp_limit` consecutive rising edges in the hunt all sample 1, the wait ends and `timeout_err` is set. The guard burst still follows, so `done` arrives after resp_limit + GUARD_CLKS rising edges counted from the first hunt edge.
- R10: After the last sampled response bit, GUARD_CLKS more rising SD clock edges occur. `done` pulses for one cycle on the falling edge that closes the burst. At that point the SD clock is low, the line is released and `busy` goes low.
- R11: `dly_set`, when the engine is idle, loads `dly_value` into `dly_now`. With a tap of d, the response is sampled from the line as it stood d system clocks earlier. The response is still decoded correctly at every tap setting when the card changes the line right after each falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a command (accepted when idle) |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| fast_sel | input | 1 | 1: fast divider, 0: initialisation divider |
| resp_limit | input | TO_W | Rising SD clock edges to wait for a start bit (at least 1) |
| dly_set | input | 1 | Load the sampling tap (idle only) |
| dly_value | input | DLY_W | Tap value to load |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_index | output | 6 | Index field of the last response |
| rsp_arg | output | 32 | Payload field of the last response |
| crc_err | output | 1 | Response CRC7 mismatch |
| end_err | output | 1 | Response end bit was 0 |
| timeout_err | output | 1 | No start bit within the limit |
| recal_req | output | 1 | One-cycle pulse when the tap is stepped |
| dly_now | output | DLY_W | Current sampling tap |
| dly_adjusted | output | 1 | Sticky: tap was stepped since reset |
| sd_clk | output | 1 | SD clock |
| sd_cmd_out | output | 1 | Command line value when driven |
| sd_cmd_oe | output | 1 | Command line drive enable |
| sd_cmd_in | input | 1 | Command line as seen at the pad |

## Verification
The bench builds the engine with SLOW_DIV of 12 instead of the default of 250. This keeps slow-rate commands short, while the ratio still differs clearly from the fast ratio of 4, so the period and turnaround measurements can tell the two apart. TURN_GAP is set to 3 so that the paused low phase stands out from an ordinary half period. `resp_limit` is 20, which lets the silent-card case reach its timeout after a few dozen edges. The card model changes the line on the system-clock cycle after each SD falling edge. Under that model, taps 2 and 3 read each bit one SD clock late, which exercises the start-bit hunt at the later alignment.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    localparam int FRAME_BITS = 48;
    localparam int BODY_BITS  = 40;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SEND,
        PH_TURN,
        PH_HUNT,
        PH_CAPT,
        PH_GUARD
    } phase_e;

    typedef struct packed {
        logic crc_bad;
        logic end_bad;
        logic no_reply;
    } rsp_flags_t;

    typedef struct packed {
        logic [5:0]  index;
        logic [31:0] arg;
    } rsp_body_t;

    // one serial step of the x^7+x^3+1 generator
    function automatic logic [6:0] crc7_step(logic [6:0] c, logic b);
        logic fb;
        fb = c[6] ^ b;
        return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    endfunction

    function automatic logic [6:0] crc7_of(logic [BODY_BITS-1:0] d);
        logic [6:0] c;
        c = '0;
        for (int i = BODY_BITS - 1; i >= 0; i--) c = crc7_step(c, d[i]);
        return c;
    endfunction

    function automatic logic [FRAME_BITS-1:0] build_frame(logic [5:0] idx, logic [31:0] arg);
        logic [BODY_BITS-1:0] body;
        body = {2'b01, idx, arg};
        return {body, crc7_of(body), 1'b1};
    endfunction

endpackage

// File: rtl/sdcmd_clkgen.sv
module sdcmd_clkgen #(
    parameter int SLOW_DIV = 250,
    parameter int FAST_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic load,
    input  logic fast_sel,
    output logic sclk,
    output logic rise_ev,
    output logic fall_ev
);
    localparam int MAXD = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
    localparam int CW   = $clog2(MAXD + 1);
    localparam logic [CW-1:0] SLOW_W = CW'(SLOW_DIV);
    localparam logic [CW-1:0] FAST_W = CW'(FAST_DIV);

    logic [CW-1:0] div_q, cnt, half;

    assign half    = div_q >> 1;
    assign rise_ev = run && (cnt == half - 1'b1);
    assign fall_ev = run && (cnt == div_q - 1'b1);

    always_ff @(posedge clk) begin
        if (rst)       div_q <= FAST_W;
        else if (load) div_q <= fast_sel ? FAST_W : SLOW_W;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else             cnt <= fall_ev ? '0 : cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || !run)  sclk <= 1'b0;
        else if (rise_ev) sclk <= 1'b1;
        else if (fall_ev) sclk <= 1'b0;
    end

    // R3: the clock is only ever high while the generator is allowed to run
    assert_clk_gated_R3: assert property (@(posedge clk) disable iff (rst)
        sclk |-> run);

    // R2: a rising edge ends a low half of the programmed length
    assert_low_half_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> ($past(cnt) == half - 1'b1));

endmodule

// File: rtl/sdcmd_sampler.sv
module sdcmd_sampler #(
    parameter int DLY_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_in,
    input  logic             set_en,
    input  logic [DLY_W-1:0] set_val,
    input  logic             step,
    output logic             samp,
    output logic [DLY_W-1:0] dly,
    output logic             adjusted
);
    localparam int TOP = (1 << DLY_W) - 1;

    logic [TOP-1:0] stage;
    logic [TOP:0]   taps;

    for (genvar g = 0; g < TOP; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk) stage[0] <= rst ? 1'b1 : line_in;
        end else begin : g_tail
            always_ff @(posedge clk) stage[g] <= rst ? 1'b1 : stage[g-1];
        end
    end

    assign taps = {stage, line_in};
    assign samp = taps[dly];

    always_ff @(posedge clk) begin
        if (rst) begin
            dly      <= '0;
            adjusted <= 1'b0;
        end else if (set_en) begin
            dly <= set_val;
        end else if (step) begin
            dly      <= dly + 1'b1;
            adjusted <= 1'b1;
        end
    end

    // R8: a step advances the tap by one with wrap-around
    assert_step_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        (step && !set_en) |=> (dly == DLY_W'($past(dly) + 1'b1)));

    // R8: no step and no load leaves the tap alone
    assert_tap_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!step && !set_en) |=> $stable(dly));

    // R8: the adjustment flag never clears outside reset
    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        adjusted |=> adjusted);

endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
    import sdcmd_pkg::*;
#(
    parameter int SLOW_DIV   = 250,
    parameter int FAST_DIV   = 4,
    parameter int TURN_GAP   = 2,
    parameter int GUARD_CLKS = 8,
    parameter int TO_W       = 16,
    parameter int DLY_W      = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [5:0]       cmd_index,
    input  logic [31:0]      cmd_arg,
    input  logic             fast_sel,
    input  logic [TO_W-1:0]  resp_limit,
    input  logic             dly_set,
    input  logic [DLY_W-1:0] dly_value,
    output logic             busy,
    output logic             done,
    output logic [5:0]       rsp_index,
    output logic [31:0]      rsp_arg,
    output logic             crc_err,
    output logic             end_err,
    output logic             timeout_err,
    output logic             recal_req,
    output logic [DLY_W-1:0] dly_now,
    output logic             dly_adjusted,
    output logic             sd_clk,
    output logic             sd_cmd_out,
    output logic             sd_cmd_oe,
    input  logic             sd_cmd_in
);
    localparam int BCW = $clog2(FRAME_BITS);
    localparam int GW  = $clog2(GUARD_CLKS + 1);
    localparam int TW  = $clog2(TURN_GAP + 1);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(FRAME_BITS - 1);
    localparam logic [GW-1:0]  GUARD_N  = GW'(GUARD_CLKS);
    localparam logic [TW-1:0]  TURN_END = TW'(TURN_GAP - 1);

    phase_e               phase;
    logic                 run, rise_ev, fall_ev, samp, idle, accept;
    logic [FRAME_BITS-1:0] frame;
    logic [FRAME_BITS-2:0] cap;
    logic [FRAME_BITS-1:0] cap_next;
    logic [BCW-1:0]       bitc;
    logic [TW-1:0]        gap;
    logic [GW-1:0]        guardc;
    logic [TO_W-1:0]      wait_cnt;
    rsp_flags_t           flags;
    rsp_body_t            body;

    assign idle     = (phase == PH_IDLE);
    assign accept   = idle && start;
    assign cap_next = {cap, samp};

    sdcmd_clkgen #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_clk (
        .clk(clk), .rst(rst), .run(run), .load(accept), .fast_sel(fast_sel),
        .sclk(sd_clk), .rise_ev(rise_ev), .fall_ev(fall_ev)
    );

    sdcmd_sampler #(.DLY_W(DLY_W)) u_samp (
        .clk(clk), .rst(rst), .line_in(sd_cmd_in),
        .set_en(dly_set && idle), .set_val(dly_value), .step(recal_req),
        .samp(samp), .dly(dly_now), .adjusted(dly_adjusted)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            run       <= 1'b0;
            sd_cmd_oe <= 1'b0;
            frame     <= '1;
            cap       <= '0;
            bitc      <= '0;
            gap       <= '0;
            guardc    <= '0;
            wait_cnt  <= '0;
            flags     <= '0;
            body      <= '0;
            done      <= 1'b0;
            recal_req <= 1'b0;
        end else begin
            done      <= 1'b0;
            recal_req <= 1'b0;
            unique case (phase)
                PH_IDLE: if (start) begin
                    frame     <= build_frame(cmd_index, cmd_arg);
                    sd_cmd_oe <= 1'b1;
                    run       <= 1'b1;
                    bitc      <= '0;
                    flags     <= '0;
                    phase     <= PH_SEND;
                end
                PH_SEND: if (fall_ev) begin
                    if (bitc == LAST_BIT) begin
                        run       <= 1'b0;
                        sd_cmd_oe <= 1'b0;
                        gap       <= '0;
                        phase     <= PH_TURN;
                    end else begin
                        frame <= frame << 1;
                        bitc  <= bitc + 1'b1;
                    end
                end
                PH_TURN: begin
                    gap <= gap + 1'b1;
                    if (gap == TURN_END) begin
                        run      <= 1'b1;
                        wait_cnt <= '0;
                        phase    <= PH_HUNT;
                    end
                end
                PH_HUNT: if (rise_ev) begin
                    if (!samp) begin
                        cap   <= '0;
                        bitc  <= BCW'(1);
                        phase <= PH_CAPT;
                    end else if (wait_cnt == resp_limit - 1'b1) begin
                        flags.no_reply <= 1'b1;
                        guardc         <= '0;
                        phase          <= PH_GUARD;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                PH_CAPT: if (rise_ev) begin
                    cap  <= cap_next[FRAME_BITS-2:0];
                    bitc <= bitc + 1'b1;
                    if (bitc == LAST_BIT) begin
                        flags.crc_bad <= (crc7_of(cap_next[FRAME_BITS-1:8]) != cap_next[7:1]);
                        flags.end_bad <= !cap_next[0];
                        recal_req     <= (crc7_of(cap_next[FRAME_BITS-1:8]) != cap_next[7:1]);
                        body          <= cap_next[45:8];
                        guardc        <= '0;
                        phase         <= PH_GUARD;
                    end
                end
                PH_GUARD: begin
                    if (rise_ev) guardc <= guardc + 1'b1;
                    if (fall_ev && guardc == GUARD_N) begin
                        run   <= 1'b0;
                        done  <= 1'b1;
                        phase <= PH_IDLE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign busy        = !idle;
    assign sd_cmd_out  = sd_cmd_oe ? frame[FRAME_BITS-1] : 1'b1;
    assign rsp_index   = body.index;
    assign rsp_arg     = body.arg;
    assign crc_err     = flags.crc_bad;
    assign end_err     = flags.end_bad;
    assign timeout_err = flags.no_reply;

    // R3: the line is released only while the SD clock is low
    assert_release_low_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(sd_cmd_oe) |-> !sd_clk);

    // R1: the engine drives the line throughout the send phase
    assert_drive_send_R1: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SEND) |-> sd_cmd_oe);

    // R10: completion is reported with the clock parked low and the line free
    assert_done_parked_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> (!sd_clk && !sd_cmd_oe && !busy));

    // R8: a tap step is requested only together with a CRC mismatch
    assert_recal_cause_R8: assert property (@(posedge clk) disable iff (rst)
        recal_req |-> flags.crc_bad);

    // R9: a timeout never coexists with a captured-response error
    assert_timeout_alone_R9: assert property (@(posedge clk) disable iff (rst)
        flags.no_reply |-> !(flags.crc_bad || flags.end_bad));

endmodule

// File: tb/tb_sd_cmd_engine.sv
module tb_sd_cmd_engine;
    localparam int CLK_NS = 10;
    localparam int SLOW   = 12;
    localparam int FAST   = 4;
    localparam int TURN   = 3;
    localparam int GUARD  = 8;
    localparam int TOUT   = 20;

    logic        clk = 1'b0, rst = 1'b1, start = 1'b0, fast_sel = 1'b0;
    logic [5:0]  cmd_index = '0;
    logic [31:0] cmd_arg = '0;
    logic [15:0] resp_limit = 16'(TOUT);
    logic        dly_set = 1'b0;
    logic [1:0]  dly_value = '0;
    logic        busy, done, crc_err, end_err, timeout_err, recal_req, dly_adjusted;
    logic [5:0]  rsp_index;
    logic [31:0] rsp_arg;
    logic [1:0]  dly_now;
    logic        sd_clk, sd_cmd_out, sd_cmd_oe;
    logic        sd_cmd_in = 1'b1;

    sd_cmd_engine #(.SLOW_DIV(SLOW), .FAST_DIV(FAST), .TURN_GAP(TURN),
                    .GUARD_CLKS(GUARD), .TO_W(16), .DLY_W(2)) dut (
        .clk(clk), .rst(rst), .start(start), .cmd_index(cmd_index), .cmd_arg(cmd_arg),
        .fast_sel(fast_sel), .resp_limit(resp_limit), .dly_set(dly_set), .dly_value(dly_value),
        .busy(busy), .done(done), .rsp_index(rsp_index), .rsp_arg(rsp_arg),
        .crc_err(crc_err), .end_err(end_err), .timeout_err(timeout_err),
        .recal_req(recal_req), .dly_now(dly_now), .dly_adjusted(dly_adjusted),
        .sd_clk(sd_clk), .sd_cmd_out(sd_cmd_out), .sd_cmd_oe(sd_cmd_oe), .sd_cmd_in(sd_cmd_in)
    );

    always #(CLK_NS/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int  vectors = 0, miscompares = 0;
    bit  finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // CRC7, generator x^7+x^3+1, from the requirement text
    function automatic logic [6:0] ref_crc(input logic [39:0] d);
        logic [6:0] r = '0;
        for (int i = 39; i >= 0; i--) begin
            logic top = r[6] ^ d[i];
            r = {r[5:0], 1'b0};
            if (top) begin r[0] = ~r[0]; r[3] = ~r[3]; end
        end
        return r;
    endfunction

    typedef struct {
        logic [5:0]  idx;
        logic [31:0] arg;
        bit crc, endb, to, adj;
        int dly;
    } exp_t;
    exp_t sb[$];

    // card model controls
    int          mode = 0;   // 0 good, 1 bad CRC, 2 bad end bit, 3 silent
    int          lat = 1, cur_div = FAST, card_dly = 0, exp_dly = 0;
    bit          exp_adj = 0;
    logic [5:0]  c_idx = '0;
    logic [31:0] c_arg = '0;
    logic        sp = 1'b0;

    task automatic tick(output bit r, output bit f);
        @(negedge clk);
        r  = !sp && sd_clk;
        f  = sp && !sd_clk;
        sp = sd_clk;
    endtask

    initial begin : card
        logic [47:0] got, frm, rsp;
        logic [6:0]  rc7;
        int n, st0, st1, tf, rc;
        bit r, f, rel;
        forever begin
            do tick(r, f); while (!sd_cmd_oe);
            n = 0; got = '0; st0 = 0; st1 = 0;
            while (n < 48) begin
                tick(r, f);
                if (r) begin
                    got = {got[46:0], sd_cmd_out};
                    if (n == 0) st0 = cyc;
                    if (n == 1) st1 = cyc;
                    n++;
                end
            end
            frm = {2'b01, c_idx, c_arg, ref_crc({2'b01, c_idx, c_arg}), 1'b1};
            chk(got == frm, "R1", "command frame", got, frm);
            chk(st1 - st0 == cur_div, "R2", "SD clock period", st1 - st0, cur_div);
            do tick(r, f); while (!f);
            tf = cyc;
            do tick(r, f); while (!r);
            chk(cyc - tf == TURN + cur_div/2, "R3", "turnaround low time", cyc - tf, TURN + cur_div/2);
            chk(sd_cmd_oe == 1'b0, "R3", "line released at first hunt edge", sd_cmd_oe, 0);
            rc = 1;
            if (mode == 3) begin
                while (!done) begin tick(r, f); if (r) rc++; end
                chk(rc == TOUT + GUARD, "R9", "edges until timeout done", rc, TOUT + GUARD);
            end else begin
                rc7 = ref_crc({2'b00, c_idx, ~c_arg});
                if (mode == 1) rc7 = rc7 ^ 7'h01;
                rsp = {2'b00, c_idx, ~c_arg, rc7, (mode == 2) ? 1'b0 : 1'b1};
                while (rc < lat) begin tick(r, f); if (r) rc++; end
                for (int k = 47; k >= 0; k--) begin
                    do tick(r, f); while (!f);
                    sd_cmd_in = rsp[k];
                end
                rc = 0; rel = 0;
                while (!done) begin
                    tick(r, f);
                    if (r) rc++;
                    if (f && !rel) begin sd_cmd_in = 1'b1; rel = 1; end
                end
                if (card_dly < 2)
                    chk(rc == GUARD + 1, "R10", "edges after end bit", rc, GUARD + 1);
            end
        end
    end

    // monitor: pop the expected item when the engine reports completion
    always @(negedge clk) begin
        if (!rst && done) begin
            exp_t e;
            if (sb.size() == 0) begin
                chk(0, "R10", "unexpected done", 1, 0);
            end else begin
                e = sb.pop_front();
                chk(timeout_err == e.to, "R9", "timeout flag", timeout_err, e.to);
                chk(timeout_err == e.to, "R4", "start bit found", !timeout_err, !e.to);
                chk(crc_err == e.crc, "R6", "crc flag", crc_err, e.crc);
                chk(end_err == e.endb, "R7", "end flag", end_err, e.endb);
                if (!e.to) begin
                    chk(rsp_index == e.idx, "R5", "response index", rsp_index, e.idx);
                    chk(rsp_arg == e.arg, "R5", "response payload", rsp_arg, e.arg);
                end
                chk(int'(dly_now) == e.dly, "R8", "tap after command", dly_now, e.dly);
                chk(dly_adjusted == e.adj, "R8", "sticky adjust flag", dly_adjusted, e.adj);
                chk(busy == 1'b0, "R10", "busy cleared", busy, 0);
            end
        end
    end

    // driver: push expectation, launch, wait for completion
    task automatic issue(input logic [5:0] i, input logic [31:0] a, input bit fast,
                         input int m, input int l);
        exp_t e;
        c_idx = i; c_arg = a; mode = m; lat = l;
        cur_div = fast ? FAST : SLOW;
        card_dly = exp_dly;
        if (m == 1) begin exp_dly = (exp_dly + 1) % 4; exp_adj = 1; end
        e.idx = i; e.arg = ~a; e.crc = (m == 1); e.endb = (m == 2); e.to = (m == 3);
        e.dly = exp_dly; e.adj = exp_adj;
        sb.push_back(e);
        @(negedge clk);
        cmd_index = i; cmd_arg = a; fast_sel = fast; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic load_tap(input logic [1:0] v);
        @(negedge clk);
        dly_set = 1'b1; dly_value = v;
        @(negedge clk);
        dly_set = 1'b0;
        exp_dly = v;
        chk(dly_now == v, "R11", "tap load", dly_now, v);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            vectors++; miscompares++;
            $display("FAIL watchdog: actual hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin : stim
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 0, "R10", "reset busy", busy, 0);
        chk(sd_clk == 0, "R2", "reset clock low", sd_clk, 0);
        chk(sd_cmd_oe == 0, "R1", "reset line released", sd_cmd_oe, 0);
        chk(dly_now == 0, "R11", "reset tap", dly_now, 0);
        chk(dly_adjusted == 0, "R8", "reset sticky", dly_adjusted, 0);

        issue(6'h08, 32'h0000_01AA, 1'b0, 0, 2);   // R2 slow ratio
        issue(6'h11, 32'h1234_5678, 1'b1, 0, 1);   // R4 shortest latency
        issue(6'h0D, 32'hFFFF_0000, 1'b1, 0, 7);   // R4 longer latency
        issue(6'h3F, 32'h0000_0000, 1'b1, 1, 2);   // R6 R8 tap 0 -> 1
        issue(6'h2A, 32'hA5A5_5A5A, 1'b1, 0, 3);   // R5 at tap 1
        load_tap(2'd3);
        issue(6'h01, 32'h8000_0001, 1'b1, 1, 1);   // R8 wrap 3 -> 0
        issue(6'h17, 32'h0F0F_F0F0, 1'b1, 2, 2);   // R7 tap unchanged
        issue(6'h05, 32'hDEAD_BEEF, 1'b1, 3, 1);   // R9 silent card
        load_tap(2'd2);
        issue(6'h33, 32'h7654_3210, 1'b1, 0, 4);   // R11 late tap decodes
        issue(6'h12, 32'h0000_FFFF, 1'b0, 0, 5);   // R11 slow ratio, late tap

        chk(sb.size() == 0, "R10", "all commands completed", sb.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule